// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

A clocked monostable. Three control inputs are asynchronous to the clock: an active-low trigger, an active-high trigger and an active-low clear. Inside the block each one is brought into the clock domain and edge-detected. An accepted trigger loads a down-counter with a programmable width, counted in clock cycles. The output `q_o` stays high while that counter is non-zero, and `qn_o` always carries its inverse.

A trigger that arrives while a pulse is running reloads the full interval. The pulse then ends one full width after the last trigger. A trigger train faster than the width therefore holds `q_o` high without a gap. Holding the clear input low aborts any pulse. Releasing the clear input can itself start a pulse when both trigger inputs are already at their enabling levels. For a dual channel, instantiate the block twice.

Top module: `retrig_oneshot`

## Requirements
- R1: While `rst_ni` is low, `q_o` is 0 and `qn_o` is 1. The synchronisers reset to the idle levels `a_ni`=1, `b_i`=0 and `clr_ni`=1, so leaving reset never fires a trigger.
- R2: `qn_o` is the inverse of `q_o` in every cycle.
- R3: A 1-to-0 transition on `a_ni` starts a pulse only if `b_i` is 1 and `clr_ni` is 1.
- R4: A 0-to-1 transition on `b_i` starts a pulse only if `a_ni` is 0 and `clr_ni` is 1.
- R5: A 0-to-1 transition on `clr_ni` starts a pulse only if `a_ni` is 0 and `b_i` is 1.
- R6: A transition that does not meet its qualifying levels has no effect. For example, a falling edge on `a_ni` while `b_i` is 0, or a rising edge on `b_i` while `a_ni` is 1, leaves `q_o` low.
- R7: While the synchronised `clr_ni` is 0, the counter is cleared and `q_o` is 0, whatever time remains. Clear takes priority over a trigger seen in the same cycle.
- R8: A pulse lasts exactly `width_i` clock cycles, sampled when the trigger is accepted. A `width_i` of 0 gives a 1-cycle pulse.
- R9: An accepted trigger during a pulse reloads the full width. The total high time equals the cycles from the first trigger to the last trigger plus one width.
- R10: A qualifying trigger train whose period is shorter than the width keeps `q_o` high in every cycle.
- R11: The latency is fixed. A change presented on a control input acts on `q_o` after the third rising clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_ni | input | 1 | Trigger input, fires on its falling edge |
| b_i | input | 1 | Trigger input, fires on its rising edge |
| clr_ni | input | 1 | Clear input, active low; its rising edge can also trigger |
| width_i | input | CNT_W | Pulse width in clock cycles (0 is treated as 1) |
| q_o | output | 1 | Pulse output |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
Directed cases cover each trigger path on its own: the falling `a_ni` edge, the rising `b_i` edge and the release of clear. Each of these shows whether the path's qualifying levels are decoded correctly. The same edges are then repeated with a disabling level on the other input, which separates gating from plain edge detection. A clear that lands mid-pulse, and a clear that coincides with a trigger, tell abort behaviour apart from priority. A single retrigger and a fast trigger train tell a full reload apart from a counter that merely continues. Width 0 and the fixed three-edge latency are measured directly. Random levels on all inputs, with random widths, are then compared cycle by cycle against a model in the bench.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef struct packed {
    logic a_n;
    logic b;
    logic clr_n;
  } ctrl_t;

  // idle levels: no trigger can be inferred when leaving reset
  localparam ctrl_t CTRL_IDLE = '{a_n: 1'b1, b: 1'b0, clr_n: 1'b1};
endpackage

// File: rtl/sync_stage.sv
module sync_stage #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/trig_decode.sv
module trig_decode
  import oneshot_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t cur_i,
  output logic  fire_o,
  output logic  clear_o
);
  ctrl_t prev;
  logic  a_fall, b_rise, c_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= CTRL_IDLE;
    else         prev <= cur_i;
  end

  assign a_fall = prev.a_n & ~cur_i.a_n;
  assign b_rise = ~prev.b & cur_i.b;
  assign c_rise = ~prev.clr_n & cur_i.clr_n;

  // each edge is gated by the levels of the other two inputs
  assign fire_o = (a_fall & cur_i.b & cur_i.clr_n)
                | (b_rise & ~cur_i.a_n & cur_i.clr_n)
                | (c_rise & ~cur_i.a_n & cur_i.b);
  assign clear_o = ~cur_i.clr_n;
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] width_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] load_val;

  assign load_val = (width_i == '0) ? ONE : width_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (clear_i)         cnt_o <= '0;
    else if (fire_i)          cnt_o <= load_val;
    else if (cnt_o != '0)     cnt_o <= cnt_o - ONE;
  end

  assign active_o = (cnt_o != '0);
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_ni,
  input  logic             b_i,
  input  logic             clr_ni,
  input  logic [CNT_W-1:0] width_i,
  output logic             q_o,
  output logic             qn_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            raw, cur;
  logic             fire, clear, active;
  logic [CNT_W-1:0] cnt;

  assign raw = '{a_n: a_ni, b: b_i, clr_n: clr_ni};

  sync_stage #(
    .N      (CTRL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTRL_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (cur)
  );

  trig_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (cur),
    .fire_o (fire),
    .clear_o(clear)
  );

  pulse_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .clear_i (clear),
    .width_i (width_i),
    .cnt_o   (cnt),
    .active_o(active)
  );

  assign q_o  = active;
  assign qn_o = ~active;
endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fire_i,
  input logic             clear_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             q_o,
  input logic             qn_o
);
  p_compl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o != qn_o);

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !q_o);

  p_fire_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !clear_i) |=> q_o);

  p_countdown_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !fire_i && !clear_i) |=> (cnt_i == $past(cnt_i) - CNT_W'(1)));

  p_rise_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(fire_i));

  always_comb begin
    if (!rst_ni) p_reset_r1: assert (!q_o && qn_o);
  end
endmodule

bind retrig_oneshot oneshot_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .fire_i (fire),
  .clear_i(clear),
  .cnt_i  (cnt),
  .q_o    (q_o),
  .qn_o   (qn_o)
);

// File: tb/retrig_oneshot_test.sv
module retrig_oneshot_test;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_n = 1'b1, b = 1'b0, clr_n = 1'b1;
  logic [CW-1:0] width = CW'(5);
  logic          q, qn;

  int n_chk = 0, n_bad = 0;
  bit model_on = 0;

  always #4 clk = ~clk;

  retrig_oneshot #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .a_ni(a_n), .b_i(b), .clr_ni(clr_n),
    .width_i(width), .q_o(q), .qn_o(qn)
  );

  // reference: two capture edges, then decision on the third
  logic m_a1, m_a2, m_a3, m_b1, m_b2, m_b3, m_c1, m_c2, m_c3;
  int   exp_cnt;

  function automatic int eff_w(input logic [CW-1:0] w);
    return (w == '0) ? 1 : int'(w);
  endfunction

  function automatic bit fires(input bit a_old, a_now, b_old, b_now, c_old, c_now);
    return (a_old & !a_now & b_now & c_now) | (!b_old & b_now & !a_now & c_now)
         | (!c_old & c_now & !a_now & b_now);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_a1, m_a2, m_a3} <= 3'b111; {m_b1, m_b2, m_b3} <= 3'b000;
      {m_c1, m_c2, m_c3} <= 3'b111; exp_cnt <= 0;
    end else begin
      m_a1 <= a_n; m_a2 <= m_a1; m_a3 <= m_a2;
      m_b1 <= b;   m_b2 <= m_b1; m_b3 <= m_b2;
      m_c1 <= clr_n; m_c2 <= m_c1; m_c3 <= m_c2;
      if (!m_c2) exp_cnt <= 0;
      else if (fires(m_a3, m_a2, m_b3, m_b2, m_c3, m_c2)) exp_cnt <= eff_w(width);
      else if (exp_cnt > 0) exp_cnt <= exp_cnt - 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      check("R3-model", int'(q), int'(exp_cnt != 0));
      check("R2-model", int'(qn), int'(!q));
    end
  end

  // returns negedges until q seen high, then negedges it stays high
  task automatic measure(output int lat, output int len);
    lat = 0; len = 0;
    while (!q && lat < 40) begin @(negedge clk); lat++; end
    while (q && len < 200) begin @(negedge clk); len++; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int lat, len, hi;
    void'($urandom(32'h5eed_1234));
    idle(3);
    check("R1 q", int'(q), 0);
    check("R1 qn", int'(qn), 1);
    rst_n = 1'b1;
    idle(4);
    check("R1 after release", int'(q), 0);

    // R3 / R11 / R8: falling a_n, width 5
    b = 1; clr_n = 1; a_n = 1; width = 5; idle(5);
    a_n = 0;
    measure(lat, len);
    check("R11 latency", lat, 3);
    check("R3 width", len, 5);

    // R8: width 0 -> one cycle
    a_n = 1; width = 0; idle(5);
    a_n = 0;
    measure(lat, len);
    check("R8 zero width", len, 1);

    // R4: rising b with a low
    width = 4; a_n = 0; b = 0; idle(6);
    b = 1;
    measure(lat, len);
    check("R4 b edge", len, 4);

    // R5: clear release with a low, b high
    width = 7; clr_n = 0; idle(6);
    clr_n = 1;
    measure(lat, len);
    check("R5 clr edge", len, 7);

    // R6: a falls while b low; b rises while a high
    a_n = 1; b = 0; idle(6);
    a_n = 0; hi = 0;
    repeat (12) begin @(negedge clk); hi += int'(q); end
    check("R6 a gated by b", hi, 0);
    a_n = 1; idle(6);
    b = 1; hi = 0;
    repeat (12) begin @(negedge clk); hi += int'(q); end
    check("R6 b gated by a", hi, 0);

    // R7: clear aborts a long pulse
    width = 40; a_n = 1; b = 1; idle(6);
    a_n = 0;
    idle(3);
    check("R7 pulse running", int'(q), 1);
    idle(3);
    clr_n = 0;
    idle(2);
    check("R7 before clear lands", int'(q), 1);
    idle(1);
    check("R7 aborted", int'(q), 0);
    check("R7 qn", int'(qn), 1);
    idle(5);
    // clear and trigger together: clear wins; b low keeps release silent
    a_n = 1; b = 1; clr_n = 1; width = 6; idle(6);
    a_n = 0; clr_n = 0; hi = 0;
    repeat (10) begin @(negedge clk); hi += int'(q); end
    check("R7 clear priority", hi, 0);
    b = 0; idle(3); clr_n = 1; a_n = 1; idle(6);

    // R9: one retrigger 6 cycles later, width 10 -> 16 high
    width = 10; a_n = 0; b = 0; idle(6);
    b = 1; hi = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      hi += int'(q);
      if (i == 3) b = 0;
      if (i == 6) b = 1;
    end
    check("R9 retrigger total", hi, 16);

    // R10: b period 4, width 6 -> continuous high
    width = 6; b = 0; idle(20);
    b = 1; hi = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i >= 3) hi += int'(q);
      if (i % 2 == 0) b = ~b;
    end
    check("R10 full duty", hi, 38);
    b = 0; idle(20);

    // random phase compared with the reference each cycle
    model_on = 1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom % 3 == 0) a_n = ~a_n;
      if ($urandom % 3 == 0) b = ~b;
      if ($urandom % 9 == 0) clr_n = ~clr_n;
      if ($urandom % 25 == 0) width = CW'($urandom % 9);
    end
    model_on = 0;
    summary();
  end
endmodule